// File: doc/BRIEF.md
# Four-Port Parallel I/O Board

This block is an I/O board that sits on the bus of an 8-bit processor. It provides four 8-bit input ports and four 8-bit output ports, which share one window of four port addresses. The board responds only when three conditions hold together: the upper address byte is all ones, five middle address bits match a strap pattern, and the combined I/O status matches a strap polarity. Inside that window, the two lowest address bits name one port pair.

Output ports hold the last byte written to them. A write can come from the processor write strobe or from the front-panel write strobe. Input ports capture external data on a per-port strobe. They present the captured byte on the read bus only while the processor is reading that port. Each of the eight ports keeps an interrupt flag. A static map routes every flag to one of eight priority request lines, and an external priority controller consumes those lines.

Top module: `pio_quad_board`

## Requirements
- R1: The board is enabled only when address bits 6..2 equal `cfg_addr_pol` bit for bit. A `cfg_addr_pol` bit of 1 demands a high address bit, and a bit of 0 demands a low one.
- R2: The board is enabled only when address bits 15..8 are all high.
- R3: The board is enabled only when (`st_in` OR `st_out`) equals `cfg_stat_pol`.
- R4: While the board is enabled, address bits 1..0 (value p) select port pair p only. Output port p sits at `out_data[8p+7:8p]` and input port p at `ext_in_data[8p+7:8p]`.
- R5: A clock edge at which the board selects port p and `proc_wr_stb` or `panel_wr_stb` is high loads `wr_data` into output port p. The new value appears after that edge, and no other output port changes.
- R6: `rd_valid` is high exactly when the board selects a port and `bus_rd` is high. Whenever `rd_valid` is low, `rd_data` is zero.
- R7: A clock edge with `ext_in_stb[p]` high captures input slice p. A read of input port p returns the captured byte.
- R8: The input port p flag is set by its strobe and cleared by a read edge of port p. When both happen at the same edge, the flag stays set.
- R9: The output port p flag is set by a write to port p and cleared by `out_ack[p]`. When both happen at the same edge, the flag stays set.
- R10: Interrupt source s is input port s for s = 0..3 and output port s-4 for s = 4..7. Its level is `cfg_irq_map[3s+2:3s]`. `irq_lines[l]` is the OR of all set flags whose level is l.
- R11: Synchronous reset clears every output port, every input latch and every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Port address from the bus |
| st_in | input | 1 | Input-cycle status |
| st_out | input | 1 | Output-cycle status |
| proc_wr_stb | input | 1 | Processor write strobe |
| panel_wr_stb | input | 1 | Front-panel write strobe |
| bus_rd | input | 1 | Processor is taking data from the bus |
| wr_data | input | 8 | Write data bus |
| cfg_addr_pol | input | 5 | Required values of address bits 6..2 |
| cfg_stat_pol | input | 1 | Required value of the status OR |
| cfg_irq_map | input | 24 | 3-bit priority level per interrupt source |
| ext_in_data | input | 32 | External data for the four input ports |
| ext_in_stb | input | 4 | Per-port capture strobe |
| out_ack | input | 4 | Per-port output flag acknowledge |
| out_data | output | 32 | Four output port registers |
| rd_data | output | 8 | Read data, zero when not driving |
| rd_valid | output | 1 | Board is driving the read bus |
| irq_lines | output | 8 | Priority request lines |

## Verification
A wrong decode shows at once. On a read it appears in the same cycle as a wrong `rd_valid` or a wrong byte on `rd_data`. On a write it appears one edge later, as a change in the wrong `out_data` slice. A flag that sets, clears or survives wrongly shows on `irq_lines` right after the edge that caused it, on the level given by the map. A stale input latch stays hidden until the next read of that port, so every capture is followed by a read.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int N_PORT   = 4;
    localparam int SEL_W    = $clog2(N_PORT);
    localparam int N_SRC    = 2 * N_PORT;
    localparam int ADDR_W   = 16;
    localparam int MATCH_LO = 2;
    localparam int MATCH_W  = 5;
    localparam int HI_LO    = 8;

    typedef struct packed {
        logic              en;
        logic [N_PORT-1:0] sel;
    } pio_dec_t;

    function automatic logic all_match(input logic [MATCH_W-1:0] bits,
                                       input logic [MATCH_W-1:0] want);
        return &(bits ~^ want);
    endfunction
endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               st_in,
    input  logic               st_out,
    input  logic [MATCH_W-1:0] cfg_addr_pol,
    input  logic               cfg_stat_pol,
    output pio_dec_t           dec
);
    logic mid_ok, hi_ok, stat_ok;

    always_comb begin
        mid_ok  = all_match(addr[MATCH_LO +: MATCH_W], cfg_addr_pol);
        hi_ok   = &addr[ADDR_W-1:HI_LO];
        stat_ok = ((st_in | st_out) == cfg_stat_pol);
        dec.en  = mid_ok & hi_ok & stat_ok;
    end

    for (genvar p = 0; p < N_PORT; p++) begin : g_sel
        assign dec.sel[p] = dec.en && (addr[SEL_W-1:0] == SEL_W'(p));
    end
endmodule

// File: rtl/pio_in_port.sv
module pio_in_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              ext_stb,
    input  logic              rd_hit,
    output logic [DATA_W-1:0] q,
    output logic              flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            flag <= 1'b0;
        end else begin
            if (ext_stb) begin
                q    <= ext_data;
                flag <= 1'b1;
            end else if (rd_hit) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pio_out_port.sv
module pio_out_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack,
    output logic [DATA_W-1:0] q,
    output logic              flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            flag <= 1'b0;
        end else begin
            if (wr_hit) begin
                q    <= wr_data;
                flag <= 1'b1;
            end else if (ack) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pio_irq_route.sv
module pio_irq_route #(
    parameter int N_SRC = 8,
    parameter int LVL_W = 3,
    localparam int N_LINE = 1 << LVL_W
) (
    input  logic [N_SRC-1:0]       flags,
    input  logic [N_SRC*LVL_W-1:0] map,
    output logic [N_LINE-1:0]      lines
);
    for (genvar l = 0; l < N_LINE; l++) begin : g_line
        logic [N_SRC-1:0] hits;
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            assign hits[s] = flags[s] && (map[s*LVL_W +: LVL_W] == LVL_W'(l));
        end
        assign lines[l] = |hits;
    end
endmodule

// File: rtl/pio_quad_board.sv
module pio_quad_board
    import pio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 3,
    localparam int N_LINE = 1 << LVL_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     st_in,
    input  logic                     st_out,
    input  logic                     proc_wr_stb,
    input  logic                     panel_wr_stb,
    input  logic                     bus_rd,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [MATCH_W-1:0]       cfg_addr_pol,
    input  logic                     cfg_stat_pol,
    input  logic [N_SRC*LVL_W-1:0]   cfg_irq_map,
    input  logic [N_PORT*DATA_W-1:0] ext_in_data,
    input  logic [N_PORT-1:0]        ext_in_stb,
    input  logic [N_PORT-1:0]        out_ack,
    output logic [N_PORT*DATA_W-1:0] out_data,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid,
    output logic [N_LINE-1:0]        irq_lines
);
    pio_dec_t              dec;
    logic                  any_wr;
    logic [N_SRC-1:0]      flags;
    logic [DATA_W-1:0]     in_q [N_PORT];
    logic [N_PORT-1:0]     rd_hit;

    assign any_wr = proc_wr_stb | panel_wr_stb;

    pio_decode u_dec (
        .addr         (addr),
        .st_in        (st_in),
        .st_out       (st_out),
        .cfg_addr_pol (cfg_addr_pol),
        .cfg_stat_pol (cfg_stat_pol),
        .dec          (dec)
    );

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        assign rd_hit[p] = dec.sel[p] & bus_rd;

        pio_in_port #(.DATA_W(DATA_W)) u_in (
            .clk      (clk),
            .rst      (rst),
            .ext_data (ext_in_data[p*DATA_W +: DATA_W]),
            .ext_stb  (ext_in_stb[p]),
            .rd_hit   (rd_hit[p]),
            .q        (in_q[p]),
            .flag     (flags[p])
        );

        pio_out_port #(.DATA_W(DATA_W)) u_out (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (dec.sel[p] & any_wr),
            .wr_data (wr_data),
            .ack     (out_ack[p]),
            .q       (out_data[p*DATA_W +: DATA_W]),
            .flag    (flags[N_PORT+p])
        );
    end

    always_comb begin
        rd_data  = '0;
        rd_valid = |rd_hit;
        for (int p = 0; p < N_PORT; p++) begin
            if (rd_hit[p]) rd_data = rd_data | in_q[p];
        end
    end

    pio_irq_route #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_irq (
        .flags (flags),
        .map   (cfg_irq_map),
        .lines (irq_lines)
    );
endmodule

// File: rtl/pio_quad_board_chk.sv
module pio_quad_board_chk
    import pio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 3,
    localparam int N_LINE = 1 << LVL_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        addr,
    input logic                     proc_wr_stb,
    input logic                     panel_wr_stb,
    input logic                     bus_rd,
    input logic [N_PORT-1:0]        ext_in_stb,
    input logic [N_PORT*DATA_W-1:0] out_data,
    input logic [DATA_W-1:0]        rd_data,
    input logic                     rd_valid,
    input logic [N_LINE-1:0]        irq_lines
);
    // R6: driving the read bus requires a processor read
    a_r6_valid_needs_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> bus_rd);

    // R6: an idle read bus carries zero
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

    // R2: no drive without an all-high upper address byte
    a_r2_high_byte: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (&addr[ADDR_W-1:HI_LO]));

    // R5: output ports hold when neither write strobe is present
    a_r5_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !(proc_wr_stb || panel_wr_stb) |=> $stable(out_data));

    // R10: no new request line rises without a capture or a write
    a_r10_no_spurious_irq: assert property (@(posedge clk) disable iff (rst)
        (!(|ext_in_stb) && !(proc_wr_stb || panel_wr_stb))
        |=> ((irq_lines & ~$past(irq_lines)) == '0));

    // R11: reset empties ports and requests
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (out_data == '0 && irq_lines == '0));
endmodule

bind pio_quad_board pio_quad_board_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .proc_wr_stb  (proc_wr_stb),
    .panel_wr_stb (panel_wr_stb),
    .bus_rd       (bus_rd),
    .ext_in_stb   (ext_in_stb),
    .out_data     (out_data),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .irq_lines    (irq_lines)
);

// File: tb/pio_quad_board_bench.sv
`timescale 1ns/1ps
module pio_quad_board_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        st_in, st_out, proc_wr_stb, panel_wr_stb, bus_rd;
    logic [7:0]  wr_data;
    logic [4:0]  cfg_addr_pol;
    logic        cfg_stat_pol;
    logic [23:0] cfg_irq_map;
    logic [31:0] ext_in_data;
    logic [3:0]  ext_in_stb, out_ack;
    logic [31:0] out_data;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [7:0]  irq_lines;

    always #10 clk = ~clk;

    pio_quad_board u_pio_quad_board (.*);

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } sb_item_t;

    sb_item_t    sbq[$];
    event        chk_ev;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    logic [7:0]  m_in [4];
    logic [31:0] m_out;
    logic [7:0]  m_flag;
    localparam logic [15:0] BASE = 16'hFF58;

    // monitor: compares queued expectations at the falling edge
    initial forever begin
        @(chk_ev);
        @(negedge clk);
        while (sbq.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
                0: act = {23'd0, rd_valid, rd_data};
                1: act = out_data;
                default: act = {24'd0, irq_lines};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(string tag, int kind, logic [31:0] v);
        sb_item_t it;
        it.tag = tag; it.kind = kind; it.exp = v;
        sbq.push_back(it);
    endtask

    task automatic sync();
        ->chk_ev;
        wait (sbq.size() == 0);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic bit hit(logic [15:0] a, logic si, logic so);
        return (a[15:8] == 8'hFF) && (a[6:2] == cfg_addr_pol) && ((si | so) == cfg_stat_pol);
    endfunction

    function automatic logic [31:0] exp_irq();
        logic [7:0] l = '0;
        for (int s = 0; s < 8; s++)
            if (m_flag[s]) l[cfg_irq_map[3*s +: 3]] = 1'b1;
        return {24'd0, l};
    endfunction

    task automatic idle();
        addr = 16'h0000; st_in = 0; st_out = 0; proc_wr_stb = 0; panel_wr_stb = 0;
        bus_rd = 0; wr_data = 0; ext_in_stb = 0; out_ack = 0;
    endtask

    task automatic bus_write(string tag, logic [15:0] a, logic [7:0] d, bit panel, bit so, bit ak = 0);
        addr = a; st_out = so; wr_data = d;
        if (panel) panel_wr_stb = 1; else proc_wr_stb = 1;
        if (ak) out_ack[a[1:0]] = 1;
        tick();
        if (hit(a, 1'b0, so)) begin
            m_out[8*a[1:0] +: 8] = d;
            m_flag[4 + a[1:0]] = 1'b1;
        end
        idle();
        push(tag, 1, m_out);
        push(tag, 2, exp_irq());
        sync();
    endtask

    task automatic ack(string tag, int p);
        out_ack[p] = 1;
        tick();
        idle();
        m_flag[4+p] = 1'b0;
        push(tag, 2, exp_irq());
        sync();
    endtask

    task automatic load(string tag, int p, logic [7:0] d);
        ext_in_data[8*p +: 8] = d; ext_in_stb[p] = 1;
        tick();
        idle();
        m_in[p] = d; m_flag[p] = 1'b1;
        push(tag, 2, exp_irq());
        sync();
    endtask

    task automatic bus_read(string tag, logic [15:0] a, bit rd = 1);
        bit h;
        addr = a; st_in = 1; bus_rd = rd;
        #1;
        h = hit(a, 1'b1, 1'b0) && rd;
        push(tag, 0, h ? {23'd0, 1'b1, m_in[a[1:0]]} : 32'd0);
        sync();
        tick();
        idle();
        if (h) m_flag[a[1:0]] = 1'b0;
        push(tag, 2, exp_irq());
        sync();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        ext_in_data = 32'h0;
        cfg_addr_pol = 5'b10110;
        cfg_stat_pol = 1'b1;
        for (int s = 0; s < 8; s++) cfg_irq_map[3*s +: 3] = 3'(7 - s);
        m_out = 0; m_flag = 0;
        for (int p = 0; p < 4; p++) m_in[p] = 0;
        rst = 1;
        tick(); tick();
        rst = 0;
        // R11 reset state
        push("R11 reset out", 1, 0);
        push("R11 reset irq", 2, 0);
        sync();
        bus_read("R11 reset read", BASE + 16'd0);

        // R5 / R9 / R10 processor write to port 2
        bus_write("R5 proc write p2", BASE + 16'd2, 8'hA5, 0, 1);
        // R5 panel write to port 0
        bus_write("R5 panel write p0", BASE + 16'd0, 8'h3C, 1, 1);
        // R1 mismatch on address bit 4
        bus_write("R1 addr bit mismatch", (BASE ^ 16'h0010) + 16'd1, 8'h11, 0, 1);
        // R2 upper byte not all high
        bus_write("R2 high byte", 16'hFE59, 8'h22, 0, 1);
        // R3 status inactive with polarity 1
        bus_write("R3 status low ignored", BASE + 16'd3, 8'h33, 0, 0);
        // R3 inverted polarity accepts inactive status
        cfg_stat_pol = 1'b0;
        bus_write("R3 inverted polarity", BASE + 16'd3, 8'h44, 0, 0);
        cfg_stat_pol = 1'b1;

        // R9 ack clears, write+ack keeps
        ack("R9 ack clears p2", 2);
        bus_write("R9 write wins over ack", BASE + 16'd0, 8'h5A, 0, 1, 1);
        ack("R9 ack p0", 0);
        ack("R9 ack p3", 3);

        // R7 / R8 / R4 input ports
        load("R8 strobe sets p1", 1, 8'h77);
        load("R7 strobe p0", 0, 8'h10);
        load("R7 strobe p2", 2, 8'h20);
        load("R7 strobe p3", 3, 8'h30);
        bus_read("R6 not reading", BASE + 16'd1, 0);
        bus_read("R4 R7 read p1", BASE + 16'd1);
        bus_read("R4 read p2", BASE + 16'd2);
        bus_read("R4 read p0", BASE + 16'd0);
        bus_read("R6 unselected read", 16'hFE5B);
        bus_read("R1 unselected read", BASE ^ 16'h0004);

        // R8 strobe and read at the same edge: flag stays, new data later
        addr = BASE + 16'd3; st_in = 1; bus_rd = 1;
        ext_in_data[24 +: 8] = 8'hC3; ext_in_stb[3] = 1;
        tick();
        idle();
        m_in[3] = 8'hC3; m_flag[3] = 1'b1;
        push("R8 strobe wins over read", 2, exp_irq());
        sync();
        bus_read("R7 read new p3", BASE + 16'd3);

        // R11 reset in operation
        bus_write("R5 write before reset", BASE + 16'd1, 8'h99, 0, 1);
        load("R8 load before reset", 0, 8'hEE);
        rst = 1;
        tick();
        rst = 0;
        m_out = 0; m_flag = 0;
        for (int p = 0; p < 4; p++) m_in[p] = 0;
        push("R11 reset clears out", 1, 0);
        push("R11 reset clears irq", 2, 0);
        sync();
        bus_read("R11 input latch cleared", BASE + 16'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule